// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one raw NAND flash operation on an 8-bit flash bus. Software first loads a command register (two opcode bytes), a low and a high address register, a byte count and a strobe timing register through a simple register write port. It then writes a control word. That write starts the engine. The control word enables each bus phase on its own bit and also carries the chip select and the number of address cycles.

The engine runs the enabled phases in a fixed order: first command, address, write data, second command, wait for ready, read data. A phase that is disabled, or that has zero bytes, is skipped with no idle cycles. Each byte is driven with a programmable strobe low time followed by a shared strobe high time. A small dual-port byte buffer holds the data. Software fills it before a program operation. The engine fills it from index 0 during a read, and software then reads it back through its own port. The device ready/busy line passes through a two-flop synchronizer. A fixed guard time comes before the engine begins to sample it.

Typical uses are reset, read-ID, status read, block erase and page program/read sequences built from the same phase bits.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset, `op_ready` is 1, all chip-select outputs are high, both strobes are high, CLE and ALE are low, and the timing register holds write-low 5, read-low 7 and high 3 clocks.
- R2: Register selects are 0 command, 1 address low, 2 address high, 3 byte count, 4 timing, 5 control. Writing select 5 while idle starts an operation, and `op_ready` reads 0 from the clock edge of that write until the operation ends.
- R3: Control bits enable phases: bit 6 first command, bit 5 address, bit 4 write data, bit 3 second command, bit 2 wait for ready, bit 1 read data. Enabled phases run in that order, and a disabled phase or a phase with zero bytes takes no cycles.
- R4: Control bits 8:7 pick one of four active-low chip selects, which is held low for the whole operation. All chip selects are high while idle.
- R5: Control bits 11:9 give the address cycle count. Values above 5 act as 5, and 0 skips the phase. Bytes 0 to 3 come from the low address register, least significant byte first. Byte 4 comes from bits 7:0 of the high address register.
- R6: Command register bits 7:0 are the first command byte and bits 15:8 are the second. CLE is high during command bytes only, and ALE is high during address bytes only.
- R7: Timing register bits 3:0 set the write-strobe low clocks, bits 7:4 set the read-strobe low clocks, and bits 11:8 set the shared high clocks. A field of 0 acts as 1. Each written byte takes low+high clocks on the write strobe, and each read byte takes low+high clocks on the read strobe.
- R8: Write-data bytes come from buffer index 0 upward. Read-data bytes are captured on the last low clock of the read strobe and stored at buffer index 0 upward. In both cases the length is the byte count register.
- R9: The wait phase ignores ready/busy for 4 clocks. The input passes through two flip-flops, and the phase ends on the first clock after the guard that sees the synchronized input high.
- R10: Writes to any register while an operation is running are ignored.
- R11: The data bus is driven only during command, address and write-data phases, and the write and read strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| op_ready | output | 1 | 1 when idle and finished |
| buf_wr_en | input | 1 | Buffer write from software |
| buf_addr | input | AW | Buffer index for software access |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer read byte, one clock after address |
| nf_ce_n | output | 4 | Active-low chip selects |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_i | input | 8 | Bus data in |
| nf_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
Assertions watch every cycle for the bus rules: at most one chip select low and none while idle, CLE and ALE never high together, never both strobes low, no bus drive while reading, no exit from the wait phase while the synchronized ready/busy line is low, and no register change while busy. Only the bench scenarios can show the rest. These are the exact byte order on the bus, the clamping of the address count, strobe widths taken from the timing fields (including zero fields), busy durations that include the guard time, the two-clock synchronizer delay, and read data landing at the right buffer indices.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD1  = 3'd1,
    PH_ADDR  = 3'd2,
    PH_WDATA = 3'd3,
    PH_CMD2  = 3'd4,
    PH_WAIT  = 3'd5,
    PH_RDATA = 3'd6
  } phase_e;

  localparam logic [2:0] SEL_CMD  = 3'd0;
  localparam logic [2:0] SEL_ALO  = 3'd1;
  localparam logic [2:0] SEL_AHI  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_TIM  = 3'd4;
  localparam logic [2:0] SEL_CTRL = 3'd5;

  localparam logic [11:0] TIM_RESET = 12'h375;
  localparam int          MAX_ADDR_CYC = 5;

endpackage

// File: rtl/nfs_regs.sv
module nfs_regs import nfs_pkg::*; #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             accept,
  output logic [15:0]      cmd_o,
  output logic [31:0]      alo_o,
  output logic [7:0]       ahi_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [3:0]       wl_o,
  output logic [3:0]       rl_o,
  output logic [3:0]       hl_o,
  output logic             start_o,
  output logic [5:0]       en_o,
  output logic [1:0]       cs_o,
  output logic [2:0]       ac_o
);

  logic [15:0]      cmd_q;
  logic [31:0]      alo_q;
  logic [7:0]       ahi_q;
  logic [CNT_W-1:0] cnt_q;
  logic [11:0]      tim_q;
  logic             wr_ok;

  assign wr_ok = wr_en && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
      cnt_q <= '0;
      tim_q <= TIM_RESET;
    end else if (wr_ok) begin
      case (wr_sel)
        SEL_CMD: cmd_q <= wr_data[15:0];
        SEL_ALO: alo_q <= wr_data;
        SEL_AHI: ahi_q <= wr_data[7:0];
        SEL_CNT: cnt_q <= wr_data[CNT_W-1:0];
        SEL_TIM: tim_q <= wr_data[11:0];
        default: ;
      endcase
    end
  end

  assign cmd_o   = cmd_q;
  assign alo_o   = alo_q;
  assign ahi_o   = ahi_q;
  assign cnt_o   = cnt_q;
  assign wl_o    = tim_q[3:0];
  assign rl_o    = tim_q[7:4];
  assign hl_o    = tim_q[11:8];
  assign start_o = wr_ok && (wr_sel == SEL_CTRL);
  assign en_o    = wr_data[6:1];
  assign cs_o    = wr_data[8:7];
  assign ac_o    = wr_data[11:9];

  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(cmd_q) && $stable(tim_q) && $stable(alo_q) && $stable(cnt_q))) // R10
    else $error("register changed while busy");

endmodule

// File: rtl/nfs_rbsync.sv
module nfs_rbsync (
  input  logic clk,
  input  logic rst,
  input  logic rb_i,
  output logic rb_o
);

  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= rb_i;
      s2_q <= s1_q;
    end
  end

  assign rb_o = s2_q;

endmodule

// File: rtl/nfs_buf.sv
module nfs_buf #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer import nfs_pkg::*; #(
  parameter int BUF_DEPTH = 32,
  parameter int GUARD_CYC = 4,
  parameter int AW        = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          op_ready,
  input  logic          buf_wr_en,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic [3:0]    nf_ce_n,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic [7:0]    nf_dq_o,
  output logic          nf_dq_oe,
  input  logic [7:0]    nf_dq_i,
  input  logic          nf_rb
);

  localparam int CNT_W  = $clog2(BUF_DEPTH + 1);
  localparam int LEN_W  = (CNT_W > 3) ? CNT_W : 3;
  localparam int NUM_CS = 4;
  localparam logic [3:0] GUARD_LD = 4'(GUARD_CYC - 1);

  logic [15:0]      cmd_r;
  logic [31:0]      alo_r;
  logic [7:0]       ahi_r;
  logic [CNT_W-1:0] cnt_r;
  logic [3:0]       wl_r, rl_r, hl_r;
  logic             start_w;
  logic [5:0]       en_w;
  logic [1:0]       cs_w;
  logic [2:0]       ac_w;
  logic             rb_s;

  nfs_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .accept(op_ready), .cmd_o(cmd_r), .alo_o(alo_r), .ahi_o(ahi_r), .cnt_o(cnt_r),
    .wl_o(wl_r), .rl_o(rl_r), .hl_o(hl_r), .start_o(start_w), .en_o(en_w),
    .cs_o(cs_w), .ac_o(ac_w)
  );

  nfs_rbsync u_sync (.clk(clk), .rst(rst), .rb_i(nf_rb), .rb_o(rb_s));

  // state
  phase_e           ph_q, ph_d;
  logic             low_q, low_d;
  logic [3:0]       tcnt_q, tcnt_d;
  logic [CNT_W-1:0] bidx_q, bidx_d;
  logic [5:0]       en_q, en_d;
  logic [1:0]       cs_q, cs_d;
  logic [2:0]       ac_q, ac_d;
  logic             adv, enter;
  logic [3:0]       wl_ld, rl_ld, h_ld;

  assign wl_ld = (wl_r == 4'd0) ? 4'd0 : wl_r - 4'd1;
  assign rl_ld = (rl_r == 4'd0) ? 4'd0 : rl_r - 4'd1;
  assign h_ld  = (hl_r == 4'd0) ? 4'd0 : hl_r - 4'd1;

  function automatic logic [LEN_W-1:0] phase_len(input phase_e p, input logic [5:0] en,
                                                 input logic [2:0] ac, input logic [CNT_W-1:0] cnt);
    logic [LEN_W-1:0] n;
    case (p)
      PH_CMD1:  n = LEN_W'(en[5]);
      PH_ADDR:  n = en[4] ? ((ac > 3'(MAX_ADDR_CYC)) ? LEN_W'(MAX_ADDR_CYC) : LEN_W'(ac)) : '0;
      PH_WDATA: n = en[3] ? LEN_W'(cnt) : '0;
      PH_CMD2:  n = LEN_W'(en[2]);
      PH_WAIT:  n = LEN_W'(en[1]);
      PH_RDATA: n = en[0] ? LEN_W'(cnt) : '0;
      default:  n = '0;
    endcase
    return n;
  endfunction

  // lowest-numbered phase at or after 'from' that has work to do
  function automatic phase_e pick_phase(input int from, input logic [5:0] en,
                                        input logic [2:0] ac, input logic [CNT_W-1:0] cnt);
    phase_e r;
    r = PH_IDLE;
    for (int i = 6; i >= 1; i--) begin
      if (i >= from && phase_len(phase_e'(i), en, ac, cnt) != '0) r = phase_e'(i);
    end
    return r;
  endfunction

  always_comb begin
    ph_d   = ph_q;
    low_d  = low_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    en_d   = en_q;
    cs_d   = cs_q;
    ac_d   = ac_q;
    adv    = 1'b0;
    enter  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start_w) begin
          en_d  = en_w;
          cs_d  = cs_w;
          ac_d  = ac_w;
          ph_d  = pick_phase(1, en_w, ac_w, cnt_r);
          enter = 1'b1;
        end
      end
      PH_WAIT: begin
        if (tcnt_q != 4'd0) tcnt_d = tcnt_q - 4'd1;
        else if (rb_s)      adv = 1'b1;
      end
      default: begin
        if (low_q) begin
          if (tcnt_q == 4'd0) begin
            low_d  = 1'b0;
            tcnt_d = h_ld;
          end else begin
            tcnt_d = tcnt_q - 4'd1;
          end
        end else if (tcnt_q != 4'd0) begin
          tcnt_d = tcnt_q - 4'd1;
        end else if (LEN_W'(bidx_q) + LEN_W'(1) < phase_len(ph_q, en_q, ac_q, cnt_r)) begin
          bidx_d = bidx_q + CNT_W'(1);
          low_d  = 1'b1;
          tcnt_d = (ph_q == PH_RDATA) ? rl_ld : wl_ld;
        end else begin
          adv = 1'b1;
        end
      end
    endcase
    if (adv) begin
      ph_d  = pick_phase(int'(ph_q) + 1, en_q, ac_q, cnt_r);
      enter = 1'b1;
    end
    if (enter) begin
      bidx_d = '0;
      low_d  = 1'b1;
      tcnt_d = (ph_d == PH_WAIT) ? GUARD_LD : ((ph_d == PH_RDATA) ? rl_ld : wl_ld);
    end
  end

  // byte for the next cycle's bus value
  logic [7:0] abyte, dq_d;
  always_comb begin
    if (bidx_d < CNT_W'(4)) abyte = alo_r[8*bidx_d[1:0] +: 8];
    else                    abyte = ahi_r;
    case (ph_d)
      PH_CMD1: dq_d = cmd_r[7:0];
      PH_CMD2: dq_d = cmd_r[15:8];
      PH_ADDR: dq_d = abyte;
      default: dq_d = 8'h00;
    endcase
  end

  logic drive_d;
  assign drive_d = (ph_d == PH_CMD1) || (ph_d == PH_ADDR) || (ph_d == PH_WDATA) || (ph_d == PH_CMD2);

  logic [7:0] dq_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      low_q    <= 1'b0;
      tcnt_q   <= '0;
      bidx_q   <= '0;
      en_q     <= '0;
      cs_q     <= '0;
      ac_q     <= '0;
      op_ready <= 1'b1;
      nf_ce_n  <= '1;
      nf_cle   <= 1'b0;
      nf_ale   <= 1'b0;
      nf_we_n  <= 1'b1;
      nf_re_n  <= 1'b1;
      nf_dq_oe <= 1'b0;
      dq_q     <= '0;
    end else begin
      ph_q     <= ph_d;
      low_q    <= low_d;
      tcnt_q   <= tcnt_d;
      bidx_q   <= bidx_d;
      en_q     <= en_d;
      cs_q     <= cs_d;
      ac_q     <= ac_d;
      op_ready <= (ph_d == PH_IDLE);
      nf_ce_n  <= (ph_d == PH_IDLE) ? '1 : ~(NUM_CS'(1) << cs_d);
      nf_cle   <= (ph_d == PH_CMD1) || (ph_d == PH_CMD2);
      nf_ale   <= (ph_d == PH_ADDR);
      nf_we_n  <= !(low_d && drive_d);
      nf_re_n  <= !(low_d && (ph_d == PH_RDATA));
      nf_dq_oe <= drive_d;
      dq_q     <= dq_d;
    end
  end

  // buffer: port A for software, port B for the engine
  logic          cap_we;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_rdata;

  assign cap_we   = (ph_q == PH_RDATA) && low_q && (tcnt_q == 4'd0);
  assign eng_addr = (ph_q == PH_RDATA) ? bidx_q[AW-1:0] : bidx_d[AW-1:0];

  nfs_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk(clk),
    .a_we(buf_wr_en), .a_addr(buf_addr), .a_wdata(buf_wdata), .a_rdata(buf_rdata),
    .b_we(cap_we), .b_addr(eng_addr), .b_wdata(nf_dq_i), .b_rdata(eng_rdata)
  );

  assign nf_dq_o = (ph_q == PH_WDATA) ? eng_rdata : dq_q;

  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(~nf_ce_n) <= 1) // R4
    else $error("more than one chip select low");
  AST_IDLE_NO_CE: assert property (@(posedge clk) disable iff (rst)
    op_ready |-> (&nf_ce_n)) // R4
    else $error("chip select low while idle");
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale)) // R6
    else $error("CLE and ALE both high");
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!nf_we_n && !nf_re_n)) // R11
    else $error("both strobes low");
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
    !nf_re_n |-> !nf_dq_oe) // R11
    else $error("bus driven during read strobe");
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && !rb_s) |=> (ph_q == PH_WAIT)) // R9
    else $error("wait phase left while device busy");

endmodule

// File: tb/tb_nand_op_sequencer.sv
`timescale 1ns/1ps
module tb_nand_op_sequencer;

  localparam int DEPTH = 32;
  localparam int AW    = 5;
  localparam int NV    = 7;

  localparam logic [11:0] V_CTRL [NV] = '{12'h262, 12'h142, 12'h6EC, 12'hBF8, 12'hE60, 12'h042, 12'h042};
  localparam logic [15:0] V_CMD  [NV] = '{16'h0090, 16'h0070, 16'hD060, 16'h1080, 16'h00EE, 16'h0070, 16'h00FF};
  localparam logic [31:0] V_ALO  [NV] = '{32'h0, 32'h0, 32'h00123456, 32'h44332211, 32'h0A0B0C0D, 32'h0, 32'h0};
  localparam logic [7:0]  V_AHI  [NV] = '{8'h00, 8'h00, 8'h00, 8'h55, 8'h0E, 8'h00, 8'h00};
  localparam int          V_CNT  [NV] = '{16, 1, 0, 4, 0, 2, 0};
  localparam logic [15:0] V_TIM  [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0132, 16'h0000};
  localparam int          V_CYC  [NV] = '{176, 18, 44, 88, 48, 11, 2};
  localparam int          V_NWE  [NV] = '{2, 1, 5, 11, 6, 1, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic op_ready;
  logic buf_wr_en = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic [3:0] nf_ce_n;
  logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq_o, nf_dq_i;
  logic nf_rb = 1'b1;

  always #2.5 clk = ~clk;

  nand_op_sequencer #(.BUF_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .op_ready(op_ready), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
    .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  int checks = 0;
  int errors = 0;

  // bus monitor / device model
  logic       mon_clr = 1'b0;
  int         exp_rl  = 7;
  logic [7:0] lg_b  [64];
  logic [1:0] lg_k  [64];
  int         lg_w  [64];
  logic [3:0] lg_ce [64];
  int nlog = 0, nre = 0, re_badw = 0, busy_cnt = 0, we_run = 0, re_run = 0, rd_idx = 0;

  function automatic logic [7:0] dev_pat(input int j);
    return (8'(j) * 8'd5) ^ 8'h3C;
  endfunction

  assign nf_dq_i = dev_pat(rd_idx);

  always @(negedge clk) begin
    if (mon_clr) begin
      nlog = 0; nre = 0; re_badw = 0; busy_cnt = 0; we_run = 0; re_run = 0; rd_idx = 0;
    end else begin
      if (!op_ready) busy_cnt++;
      if (!nf_we_n) we_run++;
      else if (we_run != 0) begin
        if (nlog < 64) begin
          lg_b[nlog] = nf_dq_o; lg_k[nlog] = {nf_ale, nf_cle};
          lg_w[nlog] = we_run;  lg_ce[nlog] = nf_ce_n;
        end
        nlog++; we_run = 0;
      end
      if (!nf_re_n) re_run++;
      else if (re_run != 0) begin
        if (re_run != exp_rl) re_badw++;
        nre++; rd_idx++; re_run = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic buf_write(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    buf_wr_en = 1'b1; buf_addr = AW'(a); buf_wdata = d;
    @(posedge clk); #1;
    buf_wr_en = 1'b0;
  endtask

  task automatic buf_read(input int a, output logic [7:0] d);
    @(posedge clk); #1;
    buf_addr = AW'(a);
    @(posedge clk); #1;
    d = buf_rdata;
  endtask

  task automatic clear_mon();
    @(posedge clk); #1; mon_clr = 1'b1;
    @(posedge clk); #1; mon_clr = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!op_ready && g < 5000) begin
      @(negedge clk); g++;
    end
    @(negedge clk); #1;
  endtask

  function automatic int eff(input logic [3:0] f);
    return (f == 4'd0) ? 1 : int'(f);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (R2 completion) actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [11:0] cur_tim;
    logic [7:0]  exp_b [64];
    logic [1:0]  exp_k [64];
    logic [7:0]  rb;
    cur_tim = 12'h375;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(op_ready == 1'b1, "R1 ready after reset", op_ready, 1);
    check(nf_ce_n == 4'hF, "R1 chip selects high", nf_ce_n, 4'hF);
    check(nf_we_n && nf_re_n, "R1 strobes high", {nf_we_n, nf_re_n}, 2'b11);
    check(!nf_cle && !nf_ale, "R1 latch enables low", {nf_cle, nf_ale}, 0);

    for (int v = 0; v < NV; v++) begin
      int n, na, wl_e, bad_w, bad_b, bad_ce;
      logic [11:0] c;
      c = V_CTRL[v];
      if (V_TIM[v] != 16'hFFFF) begin
        write_reg(3'd4, 32'(V_TIM[v]));
        cur_tim = V_TIM[v][11:0];
      end
      write_reg(3'd0, 32'(V_CMD[v]));
      write_reg(3'd1, V_ALO[v]);
      write_reg(3'd2, 32'(V_AHI[v]));
      write_reg(3'd3, 32'(V_CNT[v]));
      for (int j = 0; j < V_CNT[v]; j++) buf_write(j, 8'hC0 + 8'(j));
      exp_rl = eff(cur_tim[7:4]);
      wl_e   = eff(cur_tim[3:0]);
      clear_mon();
      write_reg(3'd5, 32'(c));
      check(op_ready == 1'b0, $sformatf("R2 busy after start v%0d", v), op_ready, 0);
      wait_done();

      // expected byte stream from the requirements (R3 order, R5, R6, R8)
      n = 0;
      if (c[6]) begin exp_b[n] = V_CMD[v][7:0]; exp_k[n] = 2'b01; n++; end
      if (c[5]) begin
        na = (int'(c[11:9]) > 5) ? 5 : int'(c[11:9]);
        for (int j = 0; j < na; j++) begin
          exp_b[n] = (j < 4) ? V_ALO[v][8*j +: 8] : V_AHI[v];
          exp_k[n] = 2'b10; n++;
        end
      end
      if (c[4]) for (int j = 0; j < V_CNT[v]; j++) begin
        exp_b[n] = 8'hC0 + 8'(j); exp_k[n] = 2'b00; n++;
      end
      if (c[3]) begin exp_b[n] = V_CMD[v][15:8]; exp_k[n] = 2'b01; n++; end

      check(busy_cnt == V_CYC[v], $sformatf("R3/R7 busy cycles v%0d", v), busy_cnt, V_CYC[v]);
      check(nlog == n && n == V_NWE[v], $sformatf("R3 write-strobe bytes v%0d", v), nlog, V_NWE[v]);
      bad_b = 0; bad_w = 0; bad_ce = 0;
      for (int j = 0; j < n && j < nlog; j++) begin
        if (lg_b[j] != exp_b[j] || lg_k[j] != exp_k[j]) bad_b++;
        if (lg_w[j] != wl_e) bad_w++;
        if (lg_ce[j] != ~(4'b0001 << c[8:7])) bad_ce++;
      end
      check(bad_b == 0, $sformatf("R5/R6/R8 byte values and latch flags v%0d", v), bad_b, 0);
      check(bad_w == 0, $sformatf("R1/R7 write strobe width v%0d", v), bad_w, 0);
      check(bad_ce == 0, $sformatf("R4 chip select v%0d", v), bad_ce, 0);
      check(nf_ce_n == 4'hF, $sformatf("R4 idle chip selects v%0d", v), nf_ce_n, 4'hF);
      if (c[1]) begin
        int bad_r = 0;
        check(nre == V_CNT[v], $sformatf("R3/R8 read strobe count v%0d", v), nre, V_CNT[v]);
        check(re_badw == 0, $sformatf("R1/R7 read strobe width v%0d", v), re_badw, 0);
        for (int j = 0; j < V_CNT[v]; j++) begin
          buf_read(j, rb);
          if (rb != dev_pat(j)) bad_r++;
        end
        check(bad_r == 0, $sformatf("R8 read capture v%0d", v), bad_r, 0);
      end
    end

    // R9 / R10: wait phase with device busy; writes during busy ignored
    write_reg(3'd4, 32'h375);
    write_reg(3'd0, 32'h0031);
    @(posedge clk); #1 nf_rb = 1'b0;
    clear_mon();
    write_reg(3'd5, 32'h044);
    write_reg(3'd0, 32'h00AA);
    write_reg(3'd4, 32'h111);
    write_reg(3'd5, 32'h040);
    repeat (30) @(posedge clk);
    #1;
    check(op_ready == 1'b0, "R9 held busy while device busy", op_ready, 0);
    nf_rb = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(op_ready == 1'b0, "R9 two-flop synchronizer delay", op_ready, 0);
    @(posedge clk); #1;
    check(op_ready == 1'b1, "R9 release after synchronized ready", op_ready, 1);
    check(nlog == 1 && lg_b[0] == 8'h31, "R9 command before wait", lg_b[0], 8'h31);

    clear_mon();
    write_reg(3'd5, 32'h040);
    wait_done();
    check(lg_b[0] == 8'h31, "R10 command write during busy ignored", lg_b[0], 8'h31);
    check(lg_w[0] == 5, "R10 timing write during busy ignored", lg_w[0], 5);
    check(busy_cnt == 8, "R10 control write during busy did not queue", busy_cnt, 8);
    check(nf_dq_oe == 1'b0, "R11 bus released when idle", nf_dq_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule